// File: doc/BRIEF.md
# Character Display Host Bus Front End

This block is the processor-facing front end of a character display controller. A host drives a register-select line, a read/write line, an enable strobe and an 8-bit data bus. The block brings these asynchronous pins into the system clock domain and treats each falling edge of the enable strobe as one transfer. It puts complete instruction bytes and data bytes on a one-cycle command port for an execution core. Status reads return the core's busy indication together with its address counter. Data reads are served from a data register that the core refills.

The interface can work 8 bits at a time or as pairs of 4-bit transfers on the upper four data lines. It decodes the width-select bit of the function-set instruction itself, so that the next transfer is framed in the new width. The RAM arrays, instruction execution and display scanning belong to the core. The core reports its state to this block over `core_busy`, `core_ac` and the `fill_valid`/`fill_data` refill port. The block tells the core, with `rd_advance`, that a data read has finished and the next location should be fetched.

Top module: `lcd_host_if`

## Requirements
- R1: {RS,RW} selects the operation: 00 instruction write, 01 status read, 10 data write, 11 data read. A completed write gives exactly one `cmd_valid` pulse of one cycle, with `cmd_is_data` equal to RS and `cmd_byte` holding the full byte.
- R2: A status read returns the busy flag on bit 7 and `core_ac` on bits 6..0. Busy is `core_busy` OR a command issued in that same cycle.
- R3: After reset the interface is in 8-bit mode. Each enable strobe then moves one whole byte, and no command or read-advance pulse is present.
- R4: In 4-bit mode only DB7..DB4 carry data and the high nibble comes first. DB3..DB0 are ignored on writes and driven as 0 on reads. No command appears until the second nibble has been transferred, so busy cannot rise after the first nibble.
- R5: In 4-bit mode a read returns the high nibble on the first strobe and the low nibble on the second. Both nibbles come from one value captured when the first strobe rose.
- R6: A data read returns the data register. The register changes only on `fill_valid`. One `rd_advance` pulse follows each completed data read, after the second nibble in 4-bit mode.
- R7: A data write leaves the data register unchanged, so the first data read after a write returns the value fetched before it.
- R8: An instruction write of the form 001x_xxxx sets the width from bit 4 (1 = 8-bit, 0 = 4-bit). When bit 4 is 1 it also clears the nibble phase, and the phase is never left at the second nibble while in 8-bit mode.
- R9: `host_db_oe` is high only while the synchronized enable is high with RW=1. The bus is never driven during writes. Transfers are taken on the falling edge of the synchronized enable.
- R10: Status reads and first nibbles never pulse `rd_advance`, and `rd_advance` never coincides with `cmd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_e | input | 1 | Host enable strobe (asynchronous) |
| host_rs | input | 1 | Register select: 0 instruction/status, 1 data |
| host_rw | input | 1 | 1 read, 0 write |
| host_db_in | input | 8 | Data bus as seen at the pins |
| host_db_out | output | 8 | Value to drive onto the data bus |
| host_db_oe | output | 1 | Output enable for the data bus |
| core_busy | input | 1 | Execution core is processing a command |
| core_ac | input | 7 | Core address counter |
| fill_valid | input | 1 | Core presents new data-register contents |
| fill_data | input | 8 | Data-register refill value |
| cmd_valid | output | 1 | One-cycle pulse: complete write available |
| cmd_is_data | output | 1 | 1 for a data write, 0 for an instruction |
| cmd_byte | output | 8 | Assembled write byte |
| rd_advance | output | 1 | One-cycle pulse: a data read finished |

## Verification
The bench drives nibble pairs with junk on the unused low lines. A framer that used DB3..DB0 in 4-bit mode, or swapped the nibble order, would give the wrong command byte. It checks that no command exists after the first nibble. A design that issued early would show busy in the middle of a transfer. It reads data right after a write and expects the value fetched earlier. A design that forwarded the write into the data register would return the new byte instead. Width switching and reset in the middle of a nibble pair are also exercised. A phase that survived the switch would split the next 8-bit transfer or read the wrong nibble.

// File: rtl/lcd_host_pkg.sv
package lcd_host_pkg;
  localparam int unsigned LCD_DW = 8;
  localparam int unsigned LCD_NW = LCD_DW / 2;
  localparam int unsigned LCD_AW = LCD_DW - 1;

  typedef logic [LCD_DW-1:0] bus_byte_t;
  typedef logic [LCD_NW-1:0] bus_nib_t;

  typedef enum logic [1:0] {
    OP_WR_INSTR = 2'b00,
    OP_RD_STAT  = 2'b01,
    OP_WR_DATA  = 2'b10,
    OP_RD_DATA  = 2'b11
  } bus_op_e;

  function automatic bus_op_e decode_op(input logic rs, input logic rw);
    return bus_op_e'({rs, rw});
  endfunction

  function automatic logic is_width_cmd(input bus_byte_t b);
    return b[LCD_DW-1:LCD_DW-3] == 3'b001;
  endfunction

  function automatic bus_byte_t status_byte(input logic busy, input logic [LCD_AW-1:0] ac);
    return {busy, ac};
  endfunction

  function automatic bus_byte_t join_nibbles(input bus_nib_t hi, input bus_nib_t lo);
    return {hi, lo};
  endfunction

  function automatic bus_byte_t place_nibble(input bus_byte_t v, input logic low_half);
    bus_nib_t n;
    n = low_half ? v[LCD_NW-1:0] : v[LCD_DW-1:LCD_NW];
    return {n, {LCD_NW{1'b0}}};
  endfunction
endpackage

// File: rtl/lcd_sync.sv
module lcd_sync #(
  parameter int unsigned W      = 11,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/lcd_xfer_framer.sv
module lcd_xfer_framer
  import lcd_host_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      e_s,
  input  logic      rs_s,
  input  logic      rw_s,
  input  bus_byte_t db_s,
  output logic      e_fall,
  output logic      snap_en,
  output logic      low_sel,
  output logic      wide_mode,
  output logic      nib_phase,
  output logic      cmd_valid,
  output logic      cmd_is_data,
  output bus_byte_t cmd_byte,
  output logic      rd_advance
);
  logic      e_prev;
  logic      e_rise;
  bus_nib_t  hi_q;
  bus_op_e   op;
  logic      is_write;
  logic      byte_done;
  bus_byte_t assembled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) e_prev <= 1'b0;
    else        e_prev <= e_s;
  end

  assign e_rise    = e_s & ~e_prev;
  assign e_fall    = ~e_s & e_prev;
  assign op        = decode_op(rs_s, rw_s);
  assign is_write  = (op == OP_WR_INSTR) || (op == OP_WR_DATA);
  assign byte_done = wide_mode | nib_phase;
  assign assembled = wide_mode ? db_s : join_nibbles(hi_q, db_s[LCD_DW-1:LCD_NW]);
  assign snap_en   = e_rise & (wide_mode | ~nib_phase);
  assign low_sel   = ~wide_mode & nib_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_mode   <= 1'b1;
      nib_phase   <= 1'b0;
      hi_q        <= '0;
      cmd_valid   <= 1'b0;
      cmd_is_data <= 1'b0;
      cmd_byte    <= '0;
      rd_advance  <= 1'b0;
    end else begin
      cmd_valid  <= 1'b0;
      rd_advance <= 1'b0;
      if (e_fall) begin
        if (!wide_mode) nib_phase <= ~nib_phase;
        if (!wide_mode && !nib_phase && is_write) hi_q <= db_s[LCD_DW-1:LCD_NW];
        if (byte_done) begin
          if (is_write) begin
            cmd_valid   <= 1'b1;
            cmd_is_data <= rs_s;
            cmd_byte    <= assembled;
            if (op == OP_WR_INSTR && is_width_cmd(assembled)) begin
              wide_mode <= assembled[LCD_NW];
              if (assembled[LCD_NW]) nib_phase <= 1'b0;
            end
          end else if (op == OP_RD_DATA) begin
            rd_advance <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/lcd_read_path.sv
module lcd_read_path
  import lcd_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              e_s,
  input  logic              rs_s,
  input  logic              rw_s,
  input  logic              snap_en,
  input  logic              low_sel,
  input  logic              wide_mode,
  input  logic              core_busy,
  input  logic              cmd_valid,
  input  logic [LCD_AW-1:0] core_ac,
  input  logic              fill_valid,
  input  bus_byte_t         fill_data,
  output bus_byte_t         dr_q,
  output bus_byte_t         db_out,
  output logic              db_oe
);
  bus_byte_t snap_q;
  bus_byte_t snap_src;

  assign snap_src = rs_s ? dr_q : status_byte(core_busy | cmd_valid, core_ac);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q   <= '0;
      snap_q <= '0;
    end else begin
      if (fill_valid) dr_q   <= fill_data;
      if (snap_en)    snap_q <= snap_src;
    end
  end

  assign db_out = wide_mode ? snap_q : place_nibble(snap_q, low_sel);
  assign db_oe  = e_s & rw_s;
endmodule

// File: rtl/lcd_host_if.sv
module lcd_host_if
  import lcd_host_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_e,
  input  logic              host_rs,
  input  logic              host_rw,
  input  logic [LCD_DW-1:0] host_db_in,
  output logic [LCD_DW-1:0] host_db_out,
  output logic              host_db_oe,
  input  logic              core_busy,
  input  logic [LCD_AW-1:0] core_ac,
  input  logic              fill_valid,
  input  logic [LCD_DW-1:0] fill_data,
  output logic              cmd_valid,
  output logic              cmd_is_data,
  output logic [LCD_DW-1:0] cmd_byte,
  output logic              rd_advance
);
  localparam int unsigned SW = LCD_DW + 3;

  logic [SW-1:0] sync_q;
  logic          e_s, rs_s, rw_s;
  bus_byte_t     db_s;
  logic          e_fall, snap_en, low_sel, wide_mode, nib_phase;
  bus_byte_t     dr_q;

  lcd_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({host_e, host_rs, host_rw, host_db_in}),
    .q(sync_q)
  );

  assign {e_s, rs_s, rw_s, db_s} = sync_q;

  lcd_xfer_framer u_framer (
    .clk(clk), .rst_n(rst_n),
    .e_s(e_s), .rs_s(rs_s), .rw_s(rw_s), .db_s(db_s),
    .e_fall(e_fall), .snap_en(snap_en), .low_sel(low_sel),
    .wide_mode(wide_mode), .nib_phase(nib_phase),
    .cmd_valid(cmd_valid), .cmd_is_data(cmd_is_data), .cmd_byte(cmd_byte),
    .rd_advance(rd_advance)
  );

  lcd_read_path u_read (
    .clk(clk), .rst_n(rst_n),
    .e_s(e_s), .rs_s(rs_s), .rw_s(rw_s),
    .snap_en(snap_en), .low_sel(low_sel), .wide_mode(wide_mode),
    .core_busy(core_busy), .cmd_valid(cmd_valid), .core_ac(core_ac),
    .fill_valid(fill_valid), .fill_data(fill_data),
    .dr_q(dr_q), .db_out(host_db_out), .db_oe(host_db_oe)
  );
endmodule

// File: rtl/lcd_host_if_chk.sv
module lcd_host_if_chk
  import lcd_host_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      host_e,
  input logic      host_rw,
  input logic      host_db_oe,
  input logic      cmd_valid,
  input logic      rd_advance,
  input logic      e_fall,
  input logic      wide_mode,
  input logic      nib_phase,
  input logic      fill_valid,
  input bus_byte_t dr_q
);
  p_oe_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_db_oe |-> ($past(host_e, 2) && $past(host_rw, 2)));

  p_cmd_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  p_adv_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !rd_advance);

  p_phase_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wide_mode |-> !nib_phase);

  p_dr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_valid |=> $stable(dr_q));

  p_adv_after_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_advance |-> $past(e_fall));
endmodule

bind lcd_host_if lcd_host_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_e(host_e), .host_rw(host_rw),
  .host_db_oe(host_db_oe), .cmd_valid(cmd_valid), .rd_advance(rd_advance),
  .e_fall(e_fall), .wide_mode(wide_mode), .nib_phase(nib_phase),
  .fill_valid(fill_valid), .dr_q(dr_q)
);

// File: tb/tb_lcd_host_if.sv
module tb_lcd_host_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_e = 1'b0, host_rs = 1'b0, host_rw = 1'b0;
  logic [7:0] host_db_in = 8'h00;
  logic [7:0] host_db_out;
  logic       host_db_oe;
  logic       core_busy;
  logic [6:0] core_ac;
  logic       fill_valid = 1'b0;
  logic [7:0] fill_data = 8'h00;
  logic       cmd_valid, cmd_is_data, rd_advance;
  logic [7:0] cmd_byte;

  int errors = 0, checks = 0;
  bit done = 0;
  bit wide = 1;

  always #5 clk = ~clk;

  lcd_host_if dut (.*);

  // core stand-in
  logic [7:0] mem [128];
  int ac = 0, busy_cnt = 0, fill_cnt = 0, adv_cnt = 0;
  int cmd_q[$];
  assign core_busy = (busy_cnt != 0);
  assign core_ac   = ac[6:0];

  always @(posedge clk) begin
    fill_valid <= 1'b0;
    if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    if (fill_cnt == 1) begin fill_valid <= 1'b1; fill_data <= mem[ac]; end
    if (fill_cnt > 0) fill_cnt <= fill_cnt - 1;
    if (rst_n && cmd_valid) begin
      cmd_q.push_back({23'd0, cmd_is_data, cmd_byte});
      busy_cnt <= 20;
      if (cmd_is_data) begin mem[ac] <= cmd_byte; ac <= (ac + 1) % 128; end
      else if (cmd_byte[7]) begin ac <= int'(cmd_byte[6:0]); fill_cnt <= 3; end
    end
    if (rst_n && rd_advance) begin
      adv_cnt <= adv_cnt + 1; ac <= (ac + 1) % 128; fill_cnt <= 3;
    end
  end

  // per-clock reference for the output enable (R9): pins seen two edges ago
  bit h1 = 0, h2 = 0;
  always @(posedge clk) begin
    h2 <= rst_n ? h1 : 1'b0;
    h1 <= rst_n ? (host_e & host_rw) : 1'b0;
  end
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (host_db_oe !== h2) begin
        errors++;
        $display("FAIL R9 oe: got %0b expected %0b at %0t", host_db_oe, h2, $time);
      end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic strobe_w(input logic rs, input logic [7:0] v);
    @(negedge clk); host_rs = rs; host_rw = 1'b0; host_db_in = v;
    repeat (2) @(negedge clk); host_e = 1'b1;
    repeat (4) @(negedge clk); host_e = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic strobe_r(input logic rs, output logic [7:0] got);
    @(negedge clk); host_rs = rs; host_rw = 1'b1;
    repeat (2) @(negedge clk); host_e = 1'b1;
    repeat (5) @(negedge clk); got = host_db_out;
    host_e = 1'b0;
    repeat (5) @(negedge clk); host_rw = 1'b0;
  endtask

  task automatic write_byte(input logic rs, input logic [7:0] v);
    if (wide) strobe_w(rs, v);
    else begin
      strobe_w(rs, {v[7:4], 4'hA});
      strobe_w(rs, {v[3:0], 4'h5});
    end
  endtask

  task automatic read_byte(input logic rs, input string tag, output logic [7:0] v);
    logic [7:0] a, b;
    if (wide) strobe_r(rs, v);
    else begin
      strobe_r(rs, a);
      strobe_r(rs, b);
      chk({tag, " R4 low lines zero (hi)"}, a[3:0], 0);
      chk({tag, " R4 low lines zero (lo)"}, b[3:0], 0);
      v = {a[7:4], b[7:4]};
    end
  endtask

  function automatic int mem_init(input int i);
    return (i ^ 8'h3C) & 8'hFF;
  endfunction

  initial begin
    logic [7:0] v;
    int n, a0;
    for (int i = 0; i < 128; i++) mem[i] = mem_init(i)[7:0];
    repeat (4) @(negedge clk);
    chk("R3 reset oe", host_db_oe, 0);
    chk("R3 reset cmd_valid", cmd_valid, 0);
    chk("R3 reset rd_advance", rd_advance, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // status read after reset, 8-bit single strobe
    read_byte(1'b0, "stat0", v);
    chk("R2 R3 status after reset", v, 8'h00);

    // instruction write: set address 5
    write_byte(1'b0, 8'h85);
    chk("R1 one command", cmd_q.size(), 1);
    if (cmd_q.size() > 0) chk("R1 instr payload", cmd_q.pop_front(), 32'h085);
    read_byte(1'b0, "stat1", v);
    chk("R2 busy with address", v, 8'h85);
    repeat (30) @(negedge clk);
    read_byte(1'b0, "stat2", v);
    chk("R2 idle with address", v, 8'h05);

    // data reads with prefetch
    read_byte(1'b1, "rd5", v);
    chk("R6 data read at 5", v, mem_init(5));
    chk("R6 advance pulse", adv_cnt, 1);
    repeat (8) @(negedge clk);
    read_byte(1'b1, "rd6", v);
    chk("R6 data read at 6", v, mem_init(6));
    repeat (8) @(negedge clk);

    // data write then stale read
    write_byte(1'b1, 8'h77);
    chk("R1 data command", cmd_q.size(), 1);
    if (cmd_q.size() > 0) chk("R1 data payload", cmd_q.pop_front(), 32'h177);
    repeat (30) @(negedge clk);
    read_byte(1'b1, "stale", v);
    chk("R7 stale read after write", v, mem_init(7));
    repeat (8) @(negedge clk);
    read_byte(1'b1, "fresh", v);
    chk("R7 second read fresh", v, mem_init(9));
    repeat (30) @(negedge clk);

    // switch to 4-bit
    write_byte(1'b0, 8'h20);
    wide = 0;
    if (cmd_q.size() > 0) chk("R8 width command", cmd_q.pop_front(), 32'h020);
    repeat (30) @(negedge clk);

    // 4-bit instruction: check nothing after the first nibble
    strobe_w(1'b0, 8'h9F);
    chk("R4 no command after first nibble", cmd_q.size(), 0);
    checks++;
    if (core_busy !== 1'b0) begin errors++; $display("FAIL R4 busy after first nibble: got 1 expected 0"); end
    strobe_w(1'b0, 8'h0F);
    chk("R4 command after second nibble", cmd_q.size(), 1);
    if (cmd_q.size() > 0) chk("R4 nibble order", cmd_q.pop_front(), 32'h090);
    read_byte(1'b0, "stat4", v);
    chk("R5 4-bit status busy", v, 8'h90);
    repeat (30) @(negedge clk);

    // 4-bit data read
    a0 = adv_cnt;
    strobe_r(1'b1, v);
    chk("R10 no advance after first nibble", adv_cnt, a0);
    chk("R5 high nibble", v[7:4], mem_init(16) >> 4);
    strobe_r(1'b1, v);
    chk("R6 advance after second nibble", adv_cnt, a0 + 1);
    chk("R5 low nibble", v[7:4], mem_init(16) & 15);
    repeat (8) @(negedge clk);

    // status reads never advance
    a0 = adv_cnt;
    read_byte(1'b0, "stat5", v);
    chk("R10 status no advance", adv_cnt, a0);
    chk("R2 4-bit status idle", v, 8'h11);

    // back to 8-bit via DL=1 in 4-bit form
    n = cmd_q.size();
    write_byte(1'b0, 8'h30);
    wide = 1;
    chk("R8 width command count", cmd_q.size(), n + 1);
    if (cmd_q.size() > 0) chk("R8 width command byte", cmd_q.pop_back(), 32'h030);
    repeat (30) @(negedge clk);
    write_byte(1'b0, 8'h83);
    chk("R8 single strobe in 8-bit", cmd_q.size(), n + 1);
    if (cmd_q.size() > 0) chk("R8 8-bit byte", cmd_q.pop_back(), 32'h083);
    repeat (30) @(negedge clk);

    // reset in the middle of a nibble pair
    write_byte(1'b0, 8'h20);
    wide = 0;
    repeat (30) @(negedge clk);
    strobe_w(1'b0, 8'h80);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wide = 1;
    cmd_q.delete();
    repeat (3) @(negedge clk);
    write_byte(1'b0, 8'h8A);
    chk("R3 8-bit after reset count", cmd_q.size(), 1);
    if (cmd_q.size() > 0) chk("R3 8-bit after reset byte", cmd_q.pop_front(), 32'h08A);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule